// File: doc/BRIEF.md
# Rear-Plane Framebuffer Clear Engine

Before a 3D frame is rasterised, this block paints every pixel of the frame's color buffer and depth buffer with a starting value. It has two modes, chosen by one bit of a 16-bit display-control register. In solid mode, one color and one depth value, held in two clear registers, go to every pixel. In bitmap mode, each pixel takes its own 16-bit color word and 16-bit depth word from two regions of texture memory. The window into those regions is moved by two 8-bit scroll offsets, and both offsets wrap.

Both modes widen their values the same way. Each 5-bit color channel becomes 6 bits, and the 15-bit depth becomes 24 bits. Software loads the registers with 32-bit or 16-bit writes and then pulses `start`. The block sends out one pixel per cycle with a linear index, and pulses `done` once the frame is finished. All the values a clear uses are captured when it starts.

Top module: `rear_clear_engine`

## Requirements
- R1: After reset, `pix_valid`, `done` and `mem_rd_en` are low and `disp_ctrl` reads 0.
- R2: Display-control select is 0. A word write stores `reg_wr_data[15:0]`. A halfword write to the lower half stores `reg_wr_data[15:0]`. A halfword write to the upper half changes nothing. `disp_ctrl` returns the stored value.
- R3: Clear-color select is 1. It holds color in bits 14:0 and alpha in bits 20:16. Clear-depth select is 2. It holds depth in bits 14:0, X scroll in bits 23:16 and Y scroll in bits 31:24. A word write updates the whole register. A halfword write (data in `reg_wr_data[15:0]`, upper half when `reg_wr_upper`) updates only its own half.
- R4: A `start` sampled at clock edge E0 gives exactly FRAME_W*FRAME_H pixels. Pixel k (numbered from 0) is presented after edge E(k+1), with `pix_index` = k. `done` is high for a single cycle, after edge E(N+1).
- R5: A 15-bit color has red in bits 4:0, green in 9:5 and blue in 14:10. Each channel c becomes 0 when c is 0, and 2c+1 otherwise. The output packs red in bits 7:0, green in 15:8, blue in 23:16 and a 5-bit alpha in 31:24. The top bits of each byte are 0.
- R6: Depth is first formed as d*512+511. When that value is at least 0x10000 and below 0xFFFFFF, 1 more is added.
- R7: When `disp_ctrl` bit 14 is 0 at start, the clear runs in solid mode. Every pixel gets the clear color, alpha from clear-color bits 20:16, and the depth from clear-depth bits 14:0. `mem_rd_en` stays low.
- R8: When bit 14 is 1, the clear runs in bitmap mode. For column c and row r, x = (Xscroll+c) mod 256 and y = (Yscroll+r) mod 256. Color is read at byte address 0x40000+y*512+x*2, and depth at 0x60000+y*512+x*2. The read port returns data one cycle after `mem_rd_en`.
- R9: In bitmap mode, color word bits 14:0 are the color. Alpha is 31 when bit 15 is set and 0 otherwise. Depth word bits 14:0 are the depth.
- R10: A `start` during a clear is ignored. Register writes made during a clear do not change that clear's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 display control, 1 clear color, 2 clear depth |
| reg_wr_word | input | 1 | 1 for a 32-bit write, 0 for a 16-bit write |
| reg_wr_upper | input | 1 | For a 16-bit write, selects the upper half |
| reg_wr_data | input | 32 | Write data (16-bit writes use bits 15:0) |
| disp_ctrl | output | 16 | Display-control register contents |
| start | input | 1 | Begins a clear when the engine is idle |
| mem_rd_en | output | 1 | Texture-memory read request |
| mem_col_addr | output | 19 | Byte address of the color word |
| mem_dep_addr | output | 19 | Byte address of the depth word |
| mem_col_data | input | 16 | Color word, one cycle after the request |
| mem_dep_data | input | 16 | Depth word, one cycle after the request |
| pix_valid | output | 1 | A pixel is presented this cycle |
| pix_index | output | IDX_W | Linear pixel index, row-major |
| pix_color | output | 32 | Widened color with alpha |
| pix_depth | output | 24 | Widened depth |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The hardest cases to reach are wrapping of the scroll offsets inside one frame and the depth threshold edges. Scroll pairs near 255 make both x and y cross zero partway through a clear. The bench memory returns a hash of each address that also encodes the region, so a wrong base, stride or wrap shows up in the pixel values. Solid-mode clears sweep every 5-bit channel code and hit the depths 0x7F, 0x80, 0x7FFE and 0x7FFF. Separate clears pulse `start` and rewrite the clear registers halfway through a frame.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        RSEL_DISP      = 2'd0,
        RSEL_CLR_COLOR = 2'd1,
        RSEL_CLR_DEPTH = 2'd2,
        RSEL_NONE      = 2'd3
    } reg_sel_e;

    localparam int          MODE_BIT   = 14;
    localparam int          ADDR_W     = 19;
    localparam logic [18:0] COLOR_BASE = 19'h40000;
    localparam logic [18:0] DEPTH_BASE = 19'h60000;

endpackage

// File: rtl/rc_regs.sv
module rc_regs
    import rc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic        wr_word,
    input  logic        wr_upper,
    input  logic [31:0] wr_data,
    output logic [15:0] disp_q,
    output logic [14:0] clr_rgb_q,
    output logic [4:0]  clr_alpha_q,
    output logic [14:0] clr_depth_q,
    output logic [7:0]  scroll_x_q,
    output logic [7:0]  scroll_y_q
);

    typedef struct packed {
        logic [15:0] disp;
        logic [14:0] rgb;
        logic [4:0]  alpha;
        logic [14:0] depth;
        logic [7:0]  sx;
        logic [7:0]  sy;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                RSEL_DISP: begin
                    if (wr_word || !wr_upper) r_d.disp = wr_data[15:0];
                end
                RSEL_CLR_COLOR: begin
                    if (wr_word) begin
                        r_d.rgb   = wr_data[14:0];
                        r_d.alpha = wr_data[20:16];
                    end else if (wr_upper) begin
                        r_d.alpha = wr_data[4:0];
                    end else begin
                        r_d.rgb   = wr_data[14:0];
                    end
                end
                RSEL_CLR_DEPTH: begin
                    if (wr_word) begin
                        r_d.depth = wr_data[14:0];
                        r_d.sx    = wr_data[23:16];
                        r_d.sy    = wr_data[31:24];
                    end else if (wr_upper) begin
                        r_d.sx    = wr_data[7:0];
                        r_d.sy    = wr_data[15:8];
                    end else begin
                        r_d.depth = wr_data[14:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign disp_q      = r_q.disp;
    assign clr_rgb_q   = r_q.rgb;
    assign clr_alpha_q = r_q.alpha;
    assign clr_depth_q = r_q.depth;
    assign scroll_x_q  = r_q.sx;
    assign scroll_y_q  = r_q.sy;

endmodule

// File: rtl/rc_scan.sv
module rc_scan
    import rc_pkg::*;
#(
    parameter int FRAME_W = 256,
    parameter int FRAME_H = 192,
    parameter int IDX_W   = $clog2(FRAME_W * FRAME_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bitmap_sel,
    input  logic [7:0]        scroll_x,
    input  logic [7:0]        scroll_y,
    input  logic [14:0]       solid_rgb,
    input  logic [4:0]        solid_alpha,
    input  logic [14:0]       solid_depth,
    output logic              rd_en,
    output logic [ADDR_W-1:0] col_addr,
    output logic [ADDR_W-1:0] dep_addr,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_bitmap,
    output logic [14:0]       out_rgb,
    output logic [4:0]        out_alpha,
    output logic [14:0]       out_depth,
    output logic              done
);

    localparam int COL_W    = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int ROW_W    = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
    localparam int LAST_COL = FRAME_W - 1;
    localparam int LAST_ROW = FRAME_H - 1;

    typedef struct packed {
        logic              run;
        logic              bitmap;
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic [IDX_W-1:0]  idx;
        logic [7:0]        xs;
        logic [7:0]        ys;
        logic [14:0]       rgb;
        logic [4:0]        alpha;
        logic [14:0]       depth;
        logic              out_v;
        logic              out_last;
        logic              out_bm;
        logic [IDX_W-1:0]  out_idx;
        logic              done;
    } scan_t;

    scan_t s_d, s_q;
    logic  at_last;
    logic [7:0]  x_cur, y_cur;
    logic [16:0] offset;

    assign at_last = (s_q.col == COL_W'(LAST_COL)) && (s_q.row == ROW_W'(LAST_ROW));

    always_comb begin
        s_d          = s_q;
        s_d.out_v    = 1'b0;
        s_d.out_last = 1'b0;
        s_d.done     = s_q.out_v && s_q.out_last;
        if (!s_q.run) begin
            if (start) begin
                s_d.run    = 1'b1;
                s_d.bitmap = bitmap_sel;
                s_d.col    = '0;
                s_d.row    = '0;
                s_d.idx    = '0;
                s_d.xs     = scroll_x;
                s_d.ys     = scroll_y;
                s_d.rgb    = solid_rgb;
                s_d.alpha  = solid_alpha;
                s_d.depth  = solid_depth;
            end
        end else begin
            s_d.out_v    = 1'b1;
            s_d.out_last = at_last;
            s_d.out_bm   = s_q.bitmap;
            s_d.out_idx  = s_q.idx;
            if (at_last) begin
                s_d.run = 1'b0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.col == COL_W'(LAST_COL)) begin
                    s_d.col = '0;
                    s_d.row = s_q.row + 1'b1;
                end else begin
                    s_d.col = s_q.col + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Scroll origin plus position, wrapping at 8 bits in both axes.
    assign x_cur  = s_q.xs + 8'(s_q.col);
    assign y_cur  = s_q.ys + 8'(s_q.row);
    assign offset = {y_cur, x_cur, 1'b0};

    assign rd_en      = s_q.run && s_q.bitmap;
    assign col_addr   = COLOR_BASE + {2'b00, offset};
    assign dep_addr   = DEPTH_BASE + {2'b00, offset};
    assign out_valid  = s_q.out_v;
    assign out_idx    = s_q.out_idx;
    assign out_bitmap = s_q.out_bm;
    assign out_rgb    = s_q.rgb;
    assign out_alpha  = s_q.alpha;
    assign out_depth  = s_q.depth;
    assign done       = s_q.done;

endmodule

// File: rtl/rc_widen.sv
module rc_widen (
    input  logic [14:0] rgb15,
    input  logic [4:0]  alpha5,
    input  logic [14:0] depth15,
    output logic [31:0] color32,
    output logic [23:0] depth24
);

    localparam int NCHAN  = 3;
    localparam int CH_IN  = 5;
    localparam int CH_OUT = 8;

    genvar ch;
    generate
        for (ch = 0; ch < NCHAN; ch++) begin : g_chan
            logic [CH_IN-1:0] narrow;
            assign narrow = rgb15[ch*CH_IN +: CH_IN];
            assign color32[ch*CH_OUT +: CH_OUT] =
                (narrow == '0) ? 8'h00 : {2'b00, narrow, 1'b1};
        end
    endgenerate

    assign color32[31:24] = {3'b000, alpha5};

    logic [23:0] depth_base;
    logic        depth_bump;

    assign depth_base = {depth15, 9'h1FF};
    assign depth_bump = (depth_base >= 24'h010000) && (depth_base != 24'hFFFFFF);
    assign depth24    = depth_base + {23'd0, depth_bump};

endmodule

// File: rtl/rear_clear_engine.sv
module rear_clear_engine
    import rc_pkg::*;
#(
    parameter int FRAME_W = 256,
    parameter int FRAME_H = 192,
    parameter int IDX_W   = $clog2(FRAME_W * FRAME_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic              reg_wr_word,
    input  logic              reg_wr_upper,
    input  logic [31:0]       reg_wr_data,
    output logic [15:0]       disp_ctrl,
    input  logic              start,
    output logic              mem_rd_en,
    output logic [18:0]       mem_col_addr,
    output logic [18:0]       mem_dep_addr,
    input  logic [15:0]       mem_col_data,
    input  logic [15:0]       mem_dep_data,
    output logic              pix_valid,
    output logic [IDX_W-1:0]  pix_index,
    output logic [31:0]       pix_color,
    output logic [23:0]       pix_depth,
    output logic              done
);

    logic [14:0] clr_rgb, clr_depth, snap_rgb, snap_depth;
    logic [4:0]  clr_alpha, snap_alpha;
    logic [7:0]  scroll_x, scroll_y;
    logic        out_bitmap;
    logic [14:0] sel_rgb, sel_depth;
    logic [4:0]  sel_alpha;

    rc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_sel),
        .wr_word    (reg_wr_word),
        .wr_upper   (reg_wr_upper),
        .wr_data    (reg_wr_data),
        .disp_q     (disp_ctrl),
        .clr_rgb_q  (clr_rgb),
        .clr_alpha_q(clr_alpha),
        .clr_depth_q(clr_depth),
        .scroll_x_q (scroll_x),
        .scroll_y_q (scroll_y)
    );

    rc_scan #(
        .FRAME_W(FRAME_W),
        .FRAME_H(FRAME_H),
        .IDX_W  (IDX_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .bitmap_sel (disp_ctrl[MODE_BIT]),
        .scroll_x   (scroll_x),
        .scroll_y   (scroll_y),
        .solid_rgb  (clr_rgb),
        .solid_alpha(clr_alpha),
        .solid_depth(clr_depth),
        .rd_en      (mem_rd_en),
        .col_addr   (mem_col_addr),
        .dep_addr   (mem_dep_addr),
        .out_valid  (pix_valid),
        .out_idx    (pix_index),
        .out_bitmap (out_bitmap),
        .out_rgb    (snap_rgb),
        .out_alpha  (snap_alpha),
        .out_depth  (snap_depth),
        .done       (done)
    );

    // Memory data arrives in the same cycle as the staged pixel index.
    assign sel_rgb   = out_bitmap ? mem_col_data[14:0] : snap_rgb;
    assign sel_alpha = out_bitmap ? {5{mem_col_data[15]}} : snap_alpha;
    assign sel_depth = out_bitmap ? mem_dep_data[14:0] : snap_depth;

    rc_widen u_widen (
        .rgb15  (sel_rgb),
        .alpha5 (sel_alpha),
        .depth15(sel_depth),
        .color32(pix_color),
        .depth24(pix_depth)
    );

endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int FRAME_W = 256,
    parameter int FRAME_H = 192,
    parameter int IDX_W   = $clog2(FRAME_W * FRAME_H)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [1:0]       reg_wr_sel,
    input logic             reg_wr_word,
    input logic             reg_wr_upper,
    input logic [15:0]      disp_ctrl,
    input logic             mem_rd_en,
    input logic             pix_valid,
    input logic [IDX_W-1:0] pix_index,
    input logic [31:0]      pix_color,
    input logic [23:0]      pix_depth,
    input logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W * FRAME_H - 1);

    assert_index_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && $past(pix_valid) |-> pix_index == $past(pix_index) + 1'b1);

    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pix_valid) && $past(pix_index) == LAST_IDX);

    assert_read_returns_pixel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> pix_valid);

    assert_channel_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pix_color[7:6] == 2'b00 && pix_color[15:14] == 2'b00 &&
                      pix_color[23:22] == 2'b00 && pix_color[31:29] == 3'b000 &&
                      (pix_color[7:0] == 8'd0 || pix_color[0]) &&
                      (pix_color[15:8] == 8'd0 || pix_color[8]) &&
                      (pix_color[23:16] == 8'd0 || pix_color[16]));

    assert_depth_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pix_depth[8:0] == 9'h1FF ||
                      (pix_depth[8:0] == 9'h000 && pix_depth >= 24'h010200));

    assert_disp_upper_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_wr_sel == 2'd0 && !reg_wr_word && reg_wr_upper
        |=> $stable(disp_ctrl));

endmodule

bind rear_clear_engine rc_checker #(
    .FRAME_W(FRAME_W),
    .FRAME_H(FRAME_H),
    .IDX_W  (IDX_W)
) u_rc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_word (reg_wr_word),
    .reg_wr_upper(reg_wr_upper),
    .disp_ctrl   (disp_ctrl),
    .mem_rd_en   (mem_rd_en),
    .pix_valid   (pix_valid),
    .pix_index   (pix_index),
    .pix_color   (pix_color),
    .pix_depth   (pix_depth),
    .done        (done)
);

// File: tb/rear_clear_engine_bench.sv
`timescale 1ns/1ps
module rear_clear_engine_bench;

    localparam int W  = 8;
    localparam int H  = 4;
    localparam int N  = W * H;
    localparam int IW = $clog2(N);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd0;
    logic        reg_wr_word = 1'b0;
    logic        reg_wr_upper = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [15:0] disp_ctrl;
    logic        start = 1'b0;
    logic        mem_rd_en;
    logic [18:0] mem_col_addr, mem_dep_addr;
    logic [15:0] mem_col_data = '0;
    logic [15:0] mem_dep_data = '0;
    logic        pix_valid;
    logic [IW-1:0] pix_index;
    logic [31:0] pix_color;
    logic [23:0] pix_depth;
    logic        done;

    int errors = 0;
    int checks = 0;

    rear_clear_engine #(.FRAME_W(W), .FRAME_H(H)) u_rear_clear_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_word(reg_wr_word),
        .reg_wr_upper(reg_wr_upper), .reg_wr_data(reg_wr_data), .disp_ctrl(disp_ctrl),
        .start(start), .mem_rd_en(mem_rd_en), .mem_col_addr(mem_col_addr),
        .mem_dep_addr(mem_dep_addr), .mem_col_data(mem_col_data), .mem_dep_data(mem_dep_data),
        .pix_valid(pix_valid), .pix_index(pix_index), .pix_color(pix_color),
        .pix_depth(pix_depth), .done(done)
    );

    always #2.5 clk = ~clk;

    // Memory contents: hash of the halfword address, region bits folded in.
    function automatic logic [15:0] mem_word(input logic [18:0] a);
        logic [15:0] h;
        h = 16'(a[16:1] * 16'd40503) ^ 16'({14'd0, a[18:17]} * 16'h1111);
        return h;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_col_data <= mem_word(mem_col_addr);
            mem_dep_data <= mem_word(mem_dep_addr);
        end
    end

    function automatic int widen_ch(input int c);
        return (c == 0) ? 0 : 2 * c + 1;
    endfunction

    function automatic logic [31:0] exp_color(input logic [14:0] w, input int a);
        return {8'(a), 8'(widen_ch(int'(w[14:10]))), 8'(widen_ch(int'(w[9:5]))),
                8'(widen_ch(int'(w[4:0])))};
    endfunction

    function automatic logic [23:0] exp_depth(input int d);
        int z;
        z = d * 512 + 511;
        if (z >= 65536 && z < 16777215) z = z + 1;
        return 24'(z);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input bit word, input bit upper,
                      input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_word = word;
        reg_wr_upper = upper; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // One clear. c1/c2 are the clear-color and clear-depth values the bench loaded.
    task automatic run_clear(input bit bm, input logic [31:0] c1, input logic [31:0] c2,
                             input bit poke, input string req);
        int tim_err;
        int col, row, x, y;
        logic [18:0] ca;
        logic [15:0] wc, wd;
        logic [31:0] ec;
        logic [23:0] ed;
        tim_err = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= N + 3; c++) begin
            if (pix_valid !== (c >= 1 && c <= N)) tim_err++;
            if (done !== (c == N + 1)) tim_err++;
            if (mem_rd_en !== (bm && c <= N - 1)) tim_err++;
            if (pix_valid === 1'b1) begin
                if (int'(pix_index) != c - 1) tim_err++;
                col = (c - 1) % W;
                row = (c - 1) / W;
                if (bm) begin
                    x  = (int'(c2[23:16]) + col) % 256;
                    y  = (int'(c2[31:24]) + row) % 256;
                    ca = 19'(32'h40000 + y * 512 + x * 2);
                    wc = mem_word(ca);
                    wd = mem_word(ca + 19'h20000);
                    ec = exp_color(wc[14:0], wc[15] ? 31 : 0);
                    ed = exp_depth(int'(wd[14:0]));
                end else begin
                    ec = exp_color(c1[14:0], int'(c1[20:16]));
                    ed = exp_depth(int'(c2[14:0]));
                end
                check(pix_color == ec, req, $sformatf("color idx %0d", c - 1), pix_color, ec);
                check(pix_depth == ed, req, $sformatf("depth idx %0d", c - 1), pix_depth, ed);
            end
            if (poke && c == 3) begin
                start = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 2'd1;
                reg_wr_word = 1'b1; reg_wr_data = ~c1;
            end
            if (poke && c == 4) begin
                reg_wr_sel = 2'd2; reg_wr_data = ~c2;
            end
            if (poke && c == 5) begin
                start = 1'b0; reg_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        check(tim_err == 0, "R4", {req, " stream timing/index/read enable"}, tim_err, 0);
    endtask

    task automatic load_clear(input logic [31:0] c1, input logic [31:0] c2, input bit halves);
        if (halves) begin
            wr(2'd1, 1'b0, 1'b0, {16'd0, c1[15:0]});
            wr(2'd1, 1'b0, 1'b1, {16'd0, c1[31:16]});
            wr(2'd2, 1'b0, 1'b0, {16'd0, c2[15:0]});
            wr(2'd2, 1'b0, 1'b1, {16'd0, c2[31:16]});
        end else begin
            wr(2'd1, 1'b1, 1'b0, c1);
            wr(2'd2, 1'b1, 1'b0, c2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] c1, c2;
        int d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pix_valid == 1'b0, "R1", "pix_valid", pix_valid, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check(mem_rd_en == 1'b0, "R1", "mem_rd_en", mem_rd_en, 0);
        check(disp_ctrl == 16'h0, "R1", "disp_ctrl", disp_ctrl, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 display-control writes
        wr(2'd0, 1'b1, 1'b0, 32'hABCD_4321);
        check(disp_ctrl == 16'h4321, "R2", "word write keeps low half", disp_ctrl, 16'h4321);
        wr(2'd0, 1'b0, 1'b1, 32'h0000_FFFF);
        check(disp_ctrl == 16'h4321, "R2", "upper halfword ignored", disp_ctrl, 16'h4321);
        wr(2'd0, 1'b0, 1'b0, 32'h0000_1234);
        check(disp_ctrl == 16'h1234, "R2", "lower halfword", disp_ctrl, 16'h1234);
        wr(2'd0, 1'b1, 1'b0, 32'h0000_0000);
        check(disp_ctrl == 16'h0000, "R2", "word write zero", disp_ctrl, 0);

        // R5 R6 R7 solid sweep over every channel code and depth boundaries
        for (int k = 0; k < 32; k++) begin
            case (k)
                0: d = 0;
                1: d = 16'h7F;
                2: d = 16'h80;
                3: d = 16'h7FFF;
                4: d = 16'h7FFE;
                default: d = (k * 1031) & 16'h7FFF;
            endcase
            c1 = {11'd0, 5'(k), 1'b0, 5'(31 - k), 5'(k ^ 5), 5'(k)};
            c2 = {8'(k), 8'(k * 3), 1'b0, 15'(d)};
            load_clear(c1, c2, k[0]);
            run_clear(1'b0, c1, c2, 1'b0, "R7 solid sweep R5 R6");
        end

        // R3 halfword writes update only their half
        wr(2'd1, 1'b1, 1'b0, 32'h001F_7FFF);
        wr(2'd1, 1'b0, 1'b1, 32'h0000_0003);
        wr(2'd2, 1'b1, 1'b0, 32'h1234_5678);
        wr(2'd2, 1'b0, 1'b0, 32'h0000_0080);
        run_clear(1'b0, 32'h0003_7FFF, 32'h1234_0080, 1'b0, "R3 halfword upper/lower");
        wr(2'd1, 1'b0, 1'b0, 32'h0000_0421);
        run_clear(1'b0, 32'h0003_0421, 32'h1234_0080, 1'b0, "R3 halfword lower color");

        // R8 R9 bitmap mode with wrapping scroll offsets
        wr(2'd0, 1'b1, 1'b0, 32'h0000_4000);
        c1 = 32'h0;
        c2 = {8'd0, 8'd0, 16'h0};
        wr(2'd2, 1'b1, 1'b0, c2);
        run_clear(1'b1, c1, c2, 1'b0, "R8 R9 bitmap origin");
        c2 = {8'd254, 8'd250, 16'h0};
        wr(2'd2, 1'b1, 1'b0, c2);
        run_clear(1'b1, c1, c2, 1'b0, "R8 R9 bitmap x/y wrap");
        c2 = {8'd255, 8'd255, 16'h0};
        wr(2'd2, 1'b0, 1'b1, {16'd0, c2[31:16]});
        run_clear(1'b1, c1, c2, 1'b0, "R8 R3 bitmap scroll halfword");
        c2 = {8'd128, 8'd17, 16'h0};
        wr(2'd2, 1'b1, 1'b0, c2);
        run_clear(1'b1, c1, c2, 1'b0, "R8 R9 bitmap mid offsets");

        // R10 restart and register writes during a clear have no effect
        c2 = {8'd3, 8'd253, 16'h0};
        wr(2'd2, 1'b1, 1'b0, c2);
        run_clear(1'b1, c1, c2, 1'b1, "R10 bitmap mid-run poke");
        wr(2'd0, 1'b1, 1'b0, 32'h0000_0000);
        c1 = 32'h0015_2A5B;
        c2 = 32'h0000_4321;
        load_clear(c1, c2, 1'b0);
        run_clear(1'b0, c1, c2, 1'b1, "R10 solid mid-run poke");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule